// File: doc/BRIEF.md
# Self-Clocked Converter Serial Read Port

This block is the read half of a data converter's serial port in the mode where the converter drives the serial clock itself. A host pulls an active-low frame-sync input low to request a transfer. An address input and a select input choose the source register. The block then makes a serial clock from the system clock and shifts the chosen word out MSB first on a data line that is released to high impedance between transfers. High impedance is modelled as an output-enable signal next to the data pin.

The block also tracks conversion results. A new result arrives on a one-cycle parallel strobe and goes into the output data register. When that happens, the active-low data-ready flag is asserted. The flag is released only after a complete read of the output data register. An output-register read that is requested while the flag is released is refused. Reads of the control word or the calibration word never look at the flag and never change it.

Top module: `conv_rd_port`

## Requirements
- R1: After reset, `rdy_n` is 1, `sclk` is 1 and `sdata_oe` is 0.
- R2: A `new_valid` strobe that is accepted stores `new_word` and drives `rdy_n` to 0 on the next clock edge. Later accepted words overwrite it, and a read returns the newest one.
- R3: `rdy_n` returns to 1 only on the edge where a complete output-register read ends, which is the edge where `sdata_oe` falls.
- R4: An output-register read (`sel_data`=1, `cal_sel`=0) requested while `rdy_n` is 1 is refused. `sclk` stays high and `sdata_oe` stays low.
- R5: With `sel_data`=0, a read returns `ctrl_word` as exactly 24 bits and leaves `rdy_n` unchanged.
- R6: With `sel_data`=1 and `cal_sel`=1, a read returns `cal_word` as exactly 24 bits and leaves `rdy_n` unchanged.
- R7: For an output-register read, bit 5 of `ctrl_word` sets the length: 0 sends the 16 bits [23:8] and 1 sends all 24 bits.
- R8: The MSB is on `sdata` from the cycle the transfer starts. Later bits change only on falling `sclk` edges, never while `sclk` is high. Each `sclk` period is CLK_DIV system cycles, and the host samples on rising edges.
- R9: Outside a transfer, `sclk` is 1, `sdata_oe` is 0 and `sdata` is 0. A transfer ends by releasing both half a period after the last rising edge.
- R10: A `new_valid` strobe is dropped if it arrives during an output-register read, including the cycle that read starts. It neither changes the stored word nor `rdy_n`.
- R11: The word is captured when the transfer starts. Changes to `ctrl_word` or `cal_word` during the transfer do not alter the bits sent.
- R12: If `rfs_n` returns high mid-transfer, the burst stops on the next edge: `sdata_oe` goes to 0 and `sclk` to 1, and `rdy_n` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfs_n | input | 1 | Active-low read frame sync from the host |
| sel_data | input | 1 | 0 selects the control word, 1 selects output data or calibration |
| cal_sel | input | 1 | With sel_data high, 1 selects the calibration word |
| ctrl_word | input | 24 | Current control register contents; bit 5 sets output word length |
| cal_word | input | 24 | Current calibration register contents |
| new_valid | input | 1 | One-cycle strobe for a new conversion result |
| new_word | input | 24 | Conversion result |
| sclk | output | 1 | Generated serial clock, idles high |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Drive enable for sdata; 0 means high impedance |
| rdy_n | output | 1 | Active-low data-ready flag |

## Verification
A new conversion strobe can land in the same cycle as the start of a read. The expected result depends on the flag. If the flag is asserted and an output-register read starts in that cycle, the read shifts the old word and the new one is lost. If the flag is released, the read is refused and the new word is stored. The bench provokes both cases by driving the frame-sync fall and the strobe on the same edge. It then judges the bits shifted out, the flag, and a follow-up read against a model of the stored word and the flag. Strobes injected mid-burst, together with changes to the control and calibration inputs and early frame-sync releases, cover the dropped-word, snapshot and abort cases.

// File: rtl/conv_rd_port.sv
module conv_rd_port #(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16,
  parameter int LEN_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfs_n,
  input  logic              sel_data,
  input  logic              cal_sel,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [WORD_W-1:0] cal_word,
  input  logic              new_valid,
  input  logic [WORD_W-1:0] new_word,
  output logic              sclk,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              rdy_n
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = $clog2(HALF) + 1;
  localparam int BW   = $clog2(WORD_W) + 1;

  logic              rfs_q, busy, rd_out, sclk_q, oe_q, rdy_q;
  logic [DW-1:0]     div;
  logic [BW-1:0]     bitn, last;
  logic [WORD_W-1:0] sh, out_q, src;

  wire want_out = sel_data & ~cal_sel;
  wire rfs_fall = rfs_q & ~rfs_n;
  wire go       = rfs_fall & ~busy & (~want_out | ~rdy_q);
  wire go_out   = go & want_out;
  wire tick     = busy && (div == DW'(HALF - 1));
  wire fin      = tick && sclk_q && (bitn == last);
  wire quit     = busy & rfs_n & ~fin;
  wire take     = new_valid & ~go_out & ~(busy & rd_out);

  assign src = !sel_data ? ctrl_word : (cal_sel ? cal_word : out_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rfs_q  <= 1'b1;
      busy   <= 1'b0;
      rd_out <= 1'b0;
      sclk_q <= 1'b1;
      oe_q   <= 1'b0;
      rdy_q  <= 1'b1;
      div    <= '0;
      bitn   <= '0;
      last   <= '0;
      sh     <= '0;
      out_q  <= '0;
    end else begin
      rfs_q <= rfs_n;
      if (take) out_q <= new_word;
      if (take) rdy_q <= 1'b0;
      else if (fin && rd_out) rdy_q <= 1'b1;

      if (go) begin
        busy   <= 1'b1;
        rd_out <= want_out;
        sclk_q <= 1'b0;
        oe_q   <= 1'b1;
        div    <= '0;
        bitn   <= '0;
        sh     <= src;
        last   <= (want_out && !ctrl_word[LEN_BIT]) ? BW'(SHORT_W - 1) : BW'(WORD_W - 1);
      end else if (fin || quit) begin
        busy   <= 1'b0;
        rd_out <= 1'b0;
        sclk_q <= 1'b1;
        oe_q   <= 1'b0;
        div    <= '0;
      end else if (busy) begin
        if (tick) begin
          div    <= '0;
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            sh   <= sh << 1;
            bitn <= bitn + 1'b1;
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclk_q;
  assign sdata_oe = oe_q;
  assign sdata    = oe_q & sh[WORD_W-1];
  assign rdy_n    = rdy_q;
endmodule

// File: rtl/conv_rd_port_chk.sv
module conv_rd_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rfs_n,
  input logic sel_data,
  input logic cal_sel,
  input logic new_valid,
  input logic sclk,
  input logic sdata,
  input logic sdata_oe,
  input logic rdy_n
);
  p_rdy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(new_valid));

  p_rdy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> $fell(sdata_oe));

  p_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdata_oe) && $past(sel_data) && !$past(cal_sel)) |-> !$past(rdy_n));

  p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && sclk && $past(sdata_oe)) |-> $stable(sdata));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> (sclk && !sdata));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sdata_oe) && $past(rfs_n)) |-> !sdata_oe);
endmodule

bind conv_rd_port conv_rd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rfs_n(rfs_n), .sel_data(sel_data),
  .cal_sel(cal_sel), .new_valid(new_valid), .sclk(sclk), .sdata(sdata),
  .sdata_oe(sdata_oe), .rdy_n(rdy_n)
);

// File: tb/tb_conv_rd_port.sv
`timescale 1ns/1ps
module tb_conv_rd_port;
  localparam int CLK_DIV = 4;

  logic clk = 0, rst_n = 0, rfs_n = 1, sel_data = 0, cal_sel = 0, new_valid = 0;
  logic [23:0] ctrl_word = 0, cal_word = 0, new_word = 0;
  logic sclk, sdata, sdata_oe, rdy_n;

  int checks = 0, errors = 0;
  logic [23:0] mdl_out = 0;
  logic mdl_rdy_n = 1;

  always #2.5 clk = ~clk;

  conv_rd_port #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .rfs_n(rfs_n), .sel_data(sel_data), .cal_sel(cal_sel),
    .ctrl_word(ctrl_word), .cal_word(cal_word), .new_valid(new_valid), .new_word(new_word),
    .sclk(sclk), .sdata(sdata), .sdata_oe(sdata_oe), .rdy_n(rdy_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit a0, input bit cal, input logic [23:0] cw);
    return (a0 && !cal && !cw[5]) ? 16 : 24;
  endfunction

  function automatic logic [23:0] exp_bits(input logic [23:0] w, input int n);
    return w >> (24 - n);
  endfunction

  task automatic push(input logic [23:0] w, input bit check_rdy);
    @(negedge clk);
    new_valid = 1; new_word = w;
    @(negedge clk);
    new_valid = 0;
    mdl_out = w; mdl_rdy_n = 0;
    if (check_rdy) chk(rdy_n == 0, "R2", rdy_n, 0);
  endtask

  task automatic rd(input bit a0, input bit cal, input bit push_start,
                    input int inj_at, input int abort_at);
    bit is_out = a0 && !cal;
    bit refuse = is_out && mdl_rdy_n;
    logic [23:0] src = !a0 ? ctrl_word : (cal ? cal_word : mdl_out);
    int n = exp_len(a0, cal, ctrl_word);
    logic [23:0] cap = 0;
    int nb = 0, cyc = 0, last_rise = 0, bad_gap = 0;
    bit seen_oe = 0, prev_sclk = 1, injected = 0, abort_now = 0;
    logic [23:0] pw = $urandom;
    @(negedge clk);
    sel_data = a0; cal_sel = cal; rfs_n = 0;
    if (push_start) begin
      new_valid = 1; new_word = pw;
      if (!is_out || refuse) begin mdl_out = pw; mdl_rdy_n = 0; end
    end
    while (cyc < (n + 2) * CLK_DIV + 4) begin
      @(negedge clk);
      cyc++;
      new_valid = 0;
      if (sdata_oe) seen_oe = 1;
      if (seen_oe && !sdata_oe) break;
      if (!prev_sclk && sclk && sdata_oe) begin
        cap = {cap[22:0], sdata};
        if (nb > 0 && cyc - last_rise != CLK_DIV) bad_gap++;
        last_rise = cyc;
        nb++;
        if (nb == inj_at && !injected) begin
          injected = 1;
          new_valid = 1; new_word = ~pw;
          ctrl_word = ctrl_word ^ 24'hFFFFDF;
          cal_word = ~cal_word;
          if (!is_out) begin mdl_out = ~pw; mdl_rdy_n = 0; end
        end
        if (nb == abort_at) begin rfs_n = 1; abort_now = 1; end
      end
      prev_sclk = sclk;
    end
    @(negedge clk);
    new_valid = 0; rfs_n = 1;
    repeat (2) @(negedge clk);
    chk(sclk == 1 && sdata_oe == 0, "R9", {sclk, sdata_oe}, 2'b10);
    if (refuse) begin
      chk(!seen_oe, "R4", seen_oe, 0);
      chk(rdy_n == mdl_rdy_n, "R4", rdy_n, mdl_rdy_n);
    end else if (abort_now) begin
      chk(nb == abort_at, "R12", nb, abort_at);
      chk(rdy_n == mdl_rdy_n, "R12", rdy_n, mdl_rdy_n);
    end else begin
      if (is_out) mdl_rdy_n = 1;
      chk(nb == n, is_out ? "R7" : (a0 ? "R6" : "R5"), nb, n);
      chk(cap == exp_bits(src, n), injected ? "R11" : (is_out ? "R2" : (a0 ? "R6" : "R5")),
          cap, exp_bits(src, n));
      chk(bad_gap == 0, "R8", bad_gap, 0);
      chk(rdy_n == mdl_rdy_n, is_out ? "R3" : (injected ? "R10" : "R5"), rdy_n, mdl_rdy_n);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk(rdy_n == 1 && sclk == 1 && sdata_oe == 0, "R1", {rdy_n, sclk, sdata_oe}, 3'b110);
    rst_n = 1;
    ctrl_word = 24'hA5C3F0 | 24'h000020;
    cal_word = 24'h3C5A96;

    rd(1, 0, 0, -1, -1);
    push(24'h123456, 1);
    push(24'hFEDCBA, 1);
    rd(1, 0, 0, -1, -1);
    ctrl_word[5] = 0;
    push(24'h9ABCDE, 0);
    rd(1, 0, 0, -1, -1);
    rd(0, 0, 0, -1, -1);
    rd(1, 1, 0, -1, -1);
    push(24'h0F0F0F, 0);
    rd(0, 0, 0, 5, -1);
    rd(1, 1, 0, 7, -1);
    ctrl_word[5] = 1;
    rd(1, 0, 0, 4, -1);
    chk(rdy_n == 1, "R10", rdy_n, 1);
    rd(1, 0, 1, -1, -1);
    chk(rdy_n == 0, "R4", rdy_n, 0);
    rd(1, 0, 1, -1, -1);
    chk(rdy_n == 1, "R10", rdy_n, 1);
    push(24'h55AA33, 0);
    rd(1, 0, 0, -1, 6);
    rd(1, 0, 0, -1, -1);

    for (int i = 0; i < 80; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: push($urandom, 1);
        1: rd(0, 0, $urandom_range(0, 1), -1, -1);
        2: rd(1, 1, 0, $urandom_range(2, 20), -1);
        3: rd(1, 0, $urandom_range(0, 1), $urandom_range(0, 1) ? 3 : -1, -1);
        4: rd(1, 0, 0, -1, $urandom_range(2, 10));
        default: begin ctrl_word = $urandom; cal_word = $urandom; end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule